// File: doc/BRIEF.md
# Chained Bitstream Readout Memory

This block is the read side of a configuration store that feeds a stored bitstream to a programmable logic device. A shared clock steps an internal position through a small storage array. The position moves only while the chip select is asserted (`ce_n` low) and the combined enable/restart input `oe_rst_n` is high. The current contents appear either one bit at a time on lane 0 or one byte at a time on all eight lanes. The `par_mode` input picks between the two.

Several of these blocks can share one clock and one data bus. The cascade output `cas_n` of each device drives the chip select of the next one. When a device has shown its last stored position, it releases the bus and pulls `cas_n` low so the next device takes over. The bus is modelled as a value vector `dout` and a per-lane drive enable `dout_en`. A lane that is not driven reads as zero on `dout` and counts as high impedance. A write port loads the array, but only while `oe_rst_n` is low.

Top module: `cfgrom_streamer`

## Requirements
- R1: While `rst` is high or `oe_rst_n` is low, `dout_en` is 8'h00 and `cas_n` is 1. A rising clock edge in that state returns the read position to byte 0, bit 0.
- R2: The read position advances on a rising clock edge only when `ce_n` is 0 and `oe_rst_n` is 1. With `ce_n` at 1 it holds, so streaming resumes where it stopped.
- R3: While `ce_n` is 1, `dout_en` is 8'h00.
- R4: Serial mode (`par_mode`=0) drives only lane 0 (`dout_en`=8'h01). Bit 7 of each stored byte comes first and bit 0 last. The byte address steps after every eighth advancing edge.
- R5: Parallel mode (`par_mode`=1) drives all lanes (`dout_en`=8'hFF) with the whole stored byte, and the address steps on every advancing edge.
- R6: After the edge that consumes the last bit (serial) or last byte (parallel) of address DEPTH-1, `cas_n` goes low and `dout_en` becomes 8'h00. Both stay that way under any number of further clock edges.
- R7: `cas_n` goes back to 1 while `ce_n` is 1 or `oe_rst_n` is low. It goes low again when `ce_n` returns to 0 without an intervening restart.
- R8: A write (`wr_en`=1) stores `wr_data` at `wr_addr` on the clock edge only while `oe_rst_n` is 0. At any other time a write leaves the stored contents unchanged.
- R9: New output data depends only on state registered at the clock edge. The first position is visible as soon as `oe_rst_n` and `ce_n` allow driving, before any advancing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared configuration clock |
| rst | input | 1 | Synchronous active-high block reset |
| ce_n | input | 1 | Active-low chip select (from host or previous `cas_n`) |
| oe_rst_n | input | 1 | High: outputs allowed and counting allowed; low: restart and release |
| par_mode | input | 1 | 0 = one bit per clock on lane 0, 1 = one byte per clock |
| wr_en | input | 1 | Array load strobe, honoured only while `oe_rst_n` is low |
| wr_addr | input | AW | Array load address, AW = log2(DEPTH) |
| wr_data | input | 8 | Array load byte |
| dout | output | 8 | Bus value per lane, zero where not driven |
| dout_en | output | 8 | Per-lane drive enable; 0 means high impedance |
| cas_n | output | 1 | Active-low cascade select for the next device |

## Verification
The bench runs the whole array out in both modes. A wrong bit order or an off-by-one step at the byte boundary shows up as mismatches on lane 0, and an early or late end shows up as a wrong edge count before `cas_n` drops. It pauses streaming with `ce_n` mid-array, which exposes a counter that keeps running or resets on deselect. It keeps the clock running past the end, which exposes a device that wraps around and drives the shared bus again. It toggles `ce_n` and `oe_rst_n` around the finished state, which catches a cascade output that sticks low or forgets it was done. It also issues writes while outputs are enabled, which catches an array that can be corrupted during readout.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

    localparam int LANES   = 8;
    localparam int BIT_IDX = 3;

    typedef enum logic {
        MODE_SERIAL   = 1'b0,
        MODE_PARALLEL = 1'b1
    } stream_mode_e;

    typedef struct packed {
        logic [LANES-1:0] value;
        logic [LANES-1:0] enable;
    } bus_drive_t;

    // MSB-first selection: index 0 picks bit 7
    function automatic logic msb_first_bit(input logic [LANES-1:0] word,
                                           input logic [BIT_IDX-1:0] idx);
        return word[~idx];
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input stream_mode_e m);
        return (m == MODE_PARALLEL) ? {LANES{1'b1}} : {{(LANES-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/cfgrom_store.sv
module cfgrom_store
    import cfgrom_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             load_ok,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LANES-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [LANES-1:0] rd_data
);

    logic [LANES-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && load_ok) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cfgrom_addr_ctr.sv
module cfgrom_addr_ctr
    import cfgrom_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               run,
    input  stream_mode_e       mode,
    output logic [AW-1:0]      addr,
    output logic [BIT_IDX-1:0] bit_idx,
    output logic               done
);

    localparam logic [AW-1:0]      LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [BIT_IDX-1:0] LAST_BIT  = '1;

    logic byte_end;
    assign byte_end = (mode == MODE_PARALLEL) || (bit_idx == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            addr    <= '0;
            bit_idx <= '0;
            done    <= 1'b0;
        end else if (run && !done) begin
            if (byte_end) begin
                bit_idx <= '0;
                if (addr == LAST_ADDR) begin
                    done <= 1'b1;
                end else begin
                    addr <= addr + 1'b1;
                end
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfgrom_out_stage.sv
module cfgrom_out_stage
    import cfgrom_pkg::*;
(
    input  logic               active,
    input  stream_mode_e       mode,
    input  logic [LANES-1:0]   word,
    input  logic [BIT_IDX-1:0] bit_idx,
    output bus_drive_t         drive
);

    always_comb begin
        drive = '0;
        if (active) begin
            drive.enable = lane_mask(mode);
            if (mode == MODE_PARALLEL) begin
                drive.value = word;
            end else begin
                drive.value = {{(LANES-1){1'b0}}, msb_first_bit(word, bit_idx)};
            end
        end
    end

endmodule

// File: rtl/cfgrom_streamer.sv
module cfgrom_streamer
    import cfgrom_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_rst_n,
    input  logic          par_mode,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    dout,
    output logic [7:0]    dout_en,
    output logic          cas_n
);

    stream_mode_e       mode;
    logic [AW-1:0]      addr_q;
    logic [BIT_IDX-1:0] bit_q;
    logic               done_q;
    logic [LANES-1:0]   word;
    logic               selected;
    bus_drive_t         drive;

    assign mode     = stream_mode_e'(par_mode);
    assign selected = !rst && !ce_n && oe_rst_n;

    cfgrom_store #(.DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .load_ok (!oe_rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr_q),
        .rd_data (word)
    );

    cfgrom_addr_ctr #(.DEPTH(DEPTH)) ctr_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (!oe_rst_n),
        .run     (!ce_n && oe_rst_n),
        .mode    (mode),
        .addr    (addr_q),
        .bit_idx (bit_q),
        .done    (done_q)
    );

    cfgrom_out_stage out_i (
        .active  (selected && !done_q),
        .mode    (mode),
        .word    (word),
        .bit_idx (bit_q),
        .drive   (drive)
    );

    assign dout    = drive.value;
    assign dout_en = drive.enable;
    assign cas_n   = !(selected && done_q);

endmodule

// File: rtl/cfgrom_streamer_chk.sv
module cfgrom_streamer_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          ce_n,
    input logic          oe_rst_n,
    input logic          par_mode,
    input logic [7:0]    dout_en,
    input logic          cas_n,
    input logic [AW-1:0] addr_q,
    input logic [2:0]    bit_q
);

    p_release_in_restart_r1: assert property (@(posedge clk) disable iff (rst)
        !oe_rst_n |-> (dout_en == 8'h00) && cas_n);

    p_hold_when_deselected_r2: assert property (@(posedge clk) disable iff (rst)
        (ce_n && oe_rst_n) |=> $stable(addr_q) && $stable(bit_q));

    p_standby_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (dout_en == 8'h00));

    p_serial_lane0_r4: assert property (@(posedge clk) disable iff (rst)
        !par_mode |-> (dout_en == 8'h00 || dout_en == 8'h01));

    p_parallel_all_r5: assert property (@(posedge clk) disable iff (rst)
        par_mode |-> (dout_en == 8'h00 || dout_en == 8'hFF));

    p_handoff_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> (dout_en == 8'h00));

    p_handoff_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && $past(oe_rst_n)) |=> (!cas_n || ce_n || !oe_rst_n));

    p_cascade_release_r7: assert property (@(posedge clk) disable iff (rst)
        (ce_n || !oe_rst_n) |-> cas_n);

endmodule

bind cfgrom_streamer cfgrom_streamer_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .oe_rst_n (oe_rst_n),
    .par_mode (par_mode),
    .dout_en  (dout_en),
    .cas_n    (cas_n),
    .addr_q   (addr_q),
    .bit_q    (bit_q)
);

// File: tb/cfgrom_streamer_tb.sv
module cfgrom_streamer_tb_top;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_rst_n = 1'b0;
    logic          par_mode = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    dout;
    logic [7:0]    dout_en;
    logic          cas_n;

    logic [7:0] model [DEPTH];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cfgrom_streamer #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_rst_n(oe_rst_n),
        .par_mode(par_mode), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dout(dout), .dout_en(dout_en), .cas_n(cas_n)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // restart (oe_rst_n low over one edge), then select in given mode
    task automatic restart_and_go(input logic pm);
        ce_n = 1'b1; oe_rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        par_mode = pm; oe_rst_n = 1'b1; ce_n = 1'b0;
        #1;
    endtask

    task automatic t_reset_state();
        chk(dout_en == 8'h00, "R1 enable in reset", dout_en, 8'h00);
        chk(cas_n == 1'b1, "R1 cascade in reset", cas_n, 1);
    endtask

    task automatic t_load();
        oe_rst_n = 1'b0; ce_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            model[i] = 8'((i * 29) ^ 8'hA5);
            wr_en = 1'b1; wr_addr = AW'(i); wr_data = model[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk(dout_en == 8'h00, "R1 enable while loading", dout_en, 8'h00);
    endtask

    task automatic t_parallel_run();
        restart_and_go(1'b1);
        for (int i = 0; i < DEPTH; i++) begin
            chk(dout == model[i], "R5 parallel byte", dout, model[i]);
            chk(dout_en == 8'hFF, "R5 parallel lanes", dout_en, 8'hFF);
            @(negedge clk);
        end
        chk(cas_n == 1'b0, "R6 cascade after last byte", cas_n, 0);
        chk(dout_en == 8'h00, "R6 release after last byte", dout_en, 8'h00);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(cas_n == 1'b0 && dout_en == 8'h00, "R6 free-running past end",
                {cas_n, dout_en}, 9'h000);
        end
    endtask

    task automatic t_cascade_release();
        ce_n = 1'b1; #1;
        chk(cas_n == 1'b1, "R7 cascade on deselect", cas_n, 1);
        @(negedge clk);
        ce_n = 1'b0; #1;
        chk(cas_n == 1'b0, "R7 cascade back after reselect", cas_n, 0);
        chk(dout_en == 8'h00, "R6 stays released after reselect", dout_en, 0);
        oe_rst_n = 1'b0; #1;
        chk(cas_n == 1'b1, "R7 cascade on restart", cas_n, 1);
        chk(dout_en == 8'h00, "R1 enable on restart", dout_en, 0);
    endtask

    task automatic t_pause_resume();
        restart_and_go(1'b1);
        chk(dout == model[0], "R9 first byte before any edge", dout, model[0]);
        repeat (3) @(negedge clk);
        ce_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(dout_en == 8'h00, "R3 standby quiet", dout_en, 0);
        end
        ce_n = 1'b0; #1;
        chk(dout == model[3], "R2 resume at held position", dout, model[3]);
        @(negedge clk);
        chk(dout == model[4], "R2 advance after resume", dout, model[4]);
        // restart mid-stream returns to byte 0
        restart_and_go(1'b1);
        chk(dout == model[0], "R1 restart mid-stream to byte 0", dout, model[0]);
    endtask

    task automatic t_serial_run();
        restart_and_go(1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            for (int b = 0; b < 8; b++) begin
                chk(dout[0] == model[i][7-b], "R4 serial bit msb first",
                    dout[0], model[i][7-b]);
                chk(dout_en == 8'h01, "R4 serial lane 0 only", dout_en, 8'h01);
                @(negedge clk);
            end
        end
        chk(cas_n == 1'b0, "R6 cascade after last serial bit", cas_n, 0);
        chk(dout_en == 8'h00, "R6 serial release", dout_en, 0);
    endtask

    task automatic t_write_guard();
        ce_n = 1'b1; oe_rst_n = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = '0; wr_data = ~model[0];
        @(negedge clk);
        wr_en = 1'b0;
        restart_and_go(1'b1);
        chk(dout == model[0], "R8 write ignored while enabled", dout, model[0]);
        ce_n = 1'b1; oe_rst_n = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(2); wr_data = 8'h5A;
        @(negedge clk);
        wr_en = 1'b0;
        model[2] = 8'h5A;
        oe_rst_n = 1'b1; ce_n = 1'b0; par_mode = 1'b1;
        repeat (2) @(negedge clk);
        chk(dout == model[2], "R8 write taken during restart", dout, model[2]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_load();
        t_parallel_run();
        t_cascade_release();
        t_pause_resume();
        t_serial_run();
        t_write_guard();
        summary();
        $finish;
    end

endmodule